// File: doc/BRIEF.md
# Dual-Compare 16-Bit PWM Timer

This block is a 16-bit up-counting timer with two compare registers and one compare output pin. Outside PWM mode the counter runs freely and wraps from 0xFFFF to 0x0000. A match on compare 1 drives the pin to a programmed level and raises output-compare flag 1. A match on compare 2 raises output-compare flag 2.

In PWM mode compare 2 sets the period and compare 1 sets the edge inside it. A compare-2 match drives the pin to level 2 and reloads the counter with 0xFFFC. A compare-1 match drives the pin to level 1. The period end is reported through capture flag 1, which can raise an interrupt. The output-compare flags stay clear in this mode.

Software reaches the block through an 8-bit register port with a 4-bit address. Each 16-bit compare value is split into a high byte and a low byte. The count advances on ticks from a prescaler. The prescaler divides the block clock by 2, 4 or 8, or it follows rising edges of a synchronised external clock.

Top module: `pwm_timer16`

## Requirements
- R1: After reset the counter holds 0xFFFC, all flags are clear, irq and cmp_out are 0, and both compares are inhibited until their low byte is written.
- R2: The prescaler field is bits [4:3] of the mode register at address 0x1. The codes are: 00 gives one count per 4 clocks, 01 one per 2 clocks, 10 one per 8 clocks, and 11 one count per rising edge of ext_clk after synchronisation. Without a tick the counter holds its value.
- R3: Outside PWM mode each tick adds one to the counter, and 0xFFFF is followed by 0x0000. The count reads back as a high byte at address 0x8 and a low byte at address 0x9.
- R4: With the PWM bit (bit 1 of address 0x1) set, a tick taken while the counter equals compare 2 loads 0xFFFC instead of incrementing. The period is therefore compare2 + 5 ticks.
- R5: In PWM mode a tick taken on a compare-2 match sets the pin to level 2 (bit 1 of address 0x0). A tick taken on a compare-1 match sets the pin to level 1 (bit 0 of address 0x0). With level 1 = 0 and level 2 = 1 the high time is compare1 + 5 ticks and the low time is compare2 − compare1 ticks. With the levels swapped the high time is compare2 − compare1 ticks.
- R6: In PWM mode a compare-2 match sets capture flag 1 (status bit 0 at address 0x2). The flag clears only on a read of address 0x3 that comes after a read of the status register.
- R7: irq is high when irq_mask is low and either of two conditions holds. The first is capture flag 1 set with capture enable (bit 2 of address 0x0) set. The second is an output-compare flag set with compare enable (bit 3 of address 0x0) set. While irq_mask is high, irq is low.
- R8: In PWM mode the output-compare flags (status bits 1 and 2) are never set. Outside PWM mode a compare-1 match sets bit 1 and drives the pin to level 1, and a compare-2 match sets bit 2. Writing the low byte of a compare clears its flag.
- R9: If the one-pulse bit (bit 2 of address 0x1) is set together with the PWM bit, the block behaves exactly as in PWM mode.
- R10: A write to a compare high byte (address 0x4 for compare 1, 0x6 for compare 2) inhibits that compare until its low byte (0x5 or 0x7) is written.
- R11: While the output enable (bit 0 of address 0x1) is clear, cmp_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe for wdata at addr |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, needed for the flag-clear sequence |
| rdata | output | 8 | Read data for addr, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq_mask | input | 1 | Global interrupt mask, high blocks irq |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the per-tick rules on every cycle. These are the reload to 0xFFFC on a PWM period match, the single-step increment, the hold without a tick, the level-2 drive and the capture-flag set on a period match. They also check that output-compare flags never rise in PWM mode, that a high-byte write inhibits its compare, and that the mask blocks irq. Only the bench scenarios can show the whole-waveform results. These are the pulse high and low durations for each prescaler and compare pair, the read-ordered flag clear, the wrap at 0xFFFF and the silent pin with the output disabled.

// File: rtl/pwm_timer16_pkg.sv
// Shared constants and types of the dual-compare PWM timer.
// Assumes a 16-bit count accessed as two bytes.
package pwm_timer16_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 3;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t RELOAD_VAL = 16'hFFFC;

    typedef enum logic [ADDR_W-1:0] {
        A_LEVELS  = 4'h0,
        A_MODE    = 4'h1,
        A_STAT    = 4'h2,
        A_CAP1_LO = 4'h3,
        A_CMP1_HI = 4'h4,
        A_CMP1_LO = 4'h5,
        A_CMP2_HI = 4'h6,
        A_CMP2_LO = 4'h7,
        A_CNT_HI  = 4'h8,
        A_CNT_LO  = 4'h9
    } reg_addr_e;

    typedef enum logic [1:0] {
        PS_DIV4 = 2'b00,
        PS_DIV2 = 2'b01,
        PS_DIV8 = 2'b10,
        PS_EXT  = 2'b11
    } presc_e;
endpackage

// File: rtl/pwm_tmr_prescale.sv
// Tick generator: divides clk by 2/4/8 or turns synchronised rising edges
// of ext_clk into single-cycle ticks. Assumes SYNC_STAGES >= 2.
module pwm_tmr_prescale
    import pwm_timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] presc,
    input  logic       ext_clk,
    output logic       tick
);
    logic [DIV_W-1:0]       div_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_rise;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Synchronise ext_clk and keep the prior sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    // Select the tick source from the prescaler code.
    always_comb begin
        unique case (presc_e'(presc))
            PS_DIV2: tick = div_q[0];
            PS_DIV4: tick = &div_q[1:0];
            PS_DIV8: tick = &div_q;
            default: tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/pwm_tmr_core.sv
// Counter, compare matching and pin level register. Match events are
// qualified by tick and by the compare arm bits. A compare-2 match in PWM
// mode wins over a compare-1 match on the pin and reloads the counter.
module pwm_tmr_core
    import pwm_timer16_pkg::*;
#(
    parameter cnt_t RELOAD = RELOAD_VAL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwm_on,
    input  cnt_t cmp1,
    input  cnt_t cmp2,
    input  logic arm1,
    input  logic arm2,
    input  logic lvl1,
    input  logic lvl2,
    output cnt_t cnt,
    output logic pin,
    output logic m1_ev,
    output logic m2_ev
);
    assign m1_ev = tick & arm1 & (cnt == cmp1);
    assign m2_ev = tick & arm2 & (cnt == cmp2);

    // Count on ticks; reload at the PWM period end.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= RELOAD;
        else if (m2_ev && pwm_on)  cnt <= RELOAD;
        else if (tick)             cnt <= cnt + 1'b1;
    end

    // Force the programmed level on each match.
    always_ff @(posedge clk) begin
        if (!rst_n)                pin <= 1'b0;
        else if (m2_ev && pwm_on)  pin <= lvl2;
        else if (m1_ev)            pin <= lvl1;
    end
endmodule

// File: rtl/pwm_timer16.sv
// Top of the dual-compare PWM timer: byte register file, flags and irq
// around the prescaler and counter core. Reads are combinational; rd_en
// only drives the flag-clear sequence.
module pwm_timer16
    import pwm_timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic              ext_clk,
    input  logic              irq_mask,
    output logic              cmp_out,
    output logic              irq
);
    logic       lvl1, lvl2, cap_ie, cmp_ie;
    logic       oe, pwm_q, opm_q;
    logic [1:0] presc;
    cnt_t       cmp1, cmp2, cnt;
    logic       arm1, arm2;
    logic       cap1, oc1, oc2, stat_seen;
    logic       tick, pin_q, m1_ev, m2_ev, pwm_on;

    // The PWM bit alone selects the mode; the one-pulse bit then has no effect.
    assign pwm_on = pwm_q;

    pwm_tmr_prescale #(.SYNC_STAGES(SYNC_STAGES)) presc_i (
        .clk(clk), .rst_n(rst_n), .presc(presc), .ext_clk(ext_clk), .tick(tick)
    );

    pwm_tmr_core #(.RELOAD(RELOAD_VAL)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_on(pwm_on),
        .cmp1(cmp1), .cmp2(cmp2), .arm1(arm1), .arm2(arm2),
        .lvl1(lvl1), .lvl2(lvl2), .cnt(cnt), .pin(pin_q),
        .m1_ev(m1_ev), .m2_ev(m2_ev)
    );

    // Control and compare registers with high-byte inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cmp_ie, cap_ie, lvl2, lvl1} <= '0;
            {presc, opm_q, pwm_q, oe}    <= '0;
            cmp1 <= '0;
            cmp2 <= '0;
            arm1 <= 1'b0;
            arm2 <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(addr))
                A_LEVELS:  {cmp_ie, cap_ie, lvl2, lvl1} <= wdata[3:0];
                A_MODE:    {presc, opm_q, pwm_q, oe}    <= wdata[4:0];
                A_CMP1_HI: begin cmp1[15:8] <= wdata; arm1 <= 1'b0; end
                A_CMP1_LO: begin cmp1[7:0]  <= wdata; arm1 <= 1'b1; end
                A_CMP2_HI: begin cmp2[15:8] <= wdata; arm2 <= 1'b0; end
                A_CMP2_LO: begin cmp2[7:0]  <= wdata; arm2 <= 1'b1; end
                default: ;
            endcase
        end
    end

    // Capture flag 1 and its read-ordered clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap1      <= 1'b0;
            stat_seen <= 1'b0;
        end else begin
            if (m2_ev && pwm_on)
                cap1 <= 1'b1;
            else if (rd_en && addr == A_CAP1_LO && stat_seen)
                cap1 <= 1'b0;
            if (rd_en && addr == A_STAT)
                stat_seen <= 1'b1;
            else if (rd_en && addr == A_CAP1_LO)
                stat_seen <= 1'b0;
        end
    end

    // Output-compare flags, active outside PWM mode only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc1 <= 1'b0;
            oc2 <= 1'b0;
        end else begin
            if (m1_ev && !pwm_on)                      oc1 <= 1'b1;
            else if (wr_en && addr == A_CMP1_LO)       oc1 <= 1'b0;
            if (m2_ev && !pwm_on)                      oc2 <= 1'b1;
            else if (wr_en && addr == A_CMP2_LO)       oc2 <= 1'b0;
        end
    end

    assign irq     = ~irq_mask & ((cap_ie & cap1) | (cmp_ie & (oc1 | oc2)));
    assign cmp_out = oe & pin_q;

    // Read mux.
    always_comb begin
        unique case (reg_addr_e'(addr))
            A_LEVELS:  rdata = {4'b0, cmp_ie, cap_ie, lvl2, lvl1};
            A_MODE:    rdata = {3'b0, presc, opm_q, pwm_q, oe};
            A_STAT:    rdata = {5'b0, oc2, oc1, cap1};
            A_CMP1_HI: rdata = cmp1[15:8];
            A_CMP1_LO: rdata = cmp1[7:0];
            A_CMP2_HI: rdata = cmp2[15:8];
            A_CMP2_LO: rdata = cmp2[7:0];
            A_CNT_HI:  rdata = cnt[15:8];
            A_CNT_LO:  rdata = cnt[7:0];
            default:   rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pwm_timer16_chk.sv
// Assertion checker for pwm_timer16, attached by bind. Observes the
// prescaler tick, core match events and registered state.
module pwm_timer16_chk
    import pwm_timer16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              pwm_on,
    input cnt_t              cnt,
    input logic              m2_ev,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              arm1,
    input logic              arm2,
    input logic              cap1,
    input logic              oc1,
    input logic              oc2,
    input logic              irq,
    input logic              irq_mask,
    input logic              cmp_out,
    input logic              lvl2,
    input logic              oe
);
    AST_PWM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (m2_ev && pwm_on) |=> (cnt == RELOAD_VAL));                          // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(m2_ev && pwm_on)) |=> (cnt == $past(cnt) + 16'd1));       // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));                                             // R2
    AST_LEVEL2_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && m2_ev && oe && !wr_en) |=> (cmp_out == $past(lvl2)));     // R5
    AST_CAP1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && m2_ev) |=> cap1);                                         // R6
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);                                                  // R7
    AST_OC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_on |=> (!$rose(oc1) && !$rose(oc2)));                            // R8
    AST_HI_INHIBIT1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMP1_HI) |=> !arm1);                             // R10
    AST_HI_INHIBIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMP2_HI) |=> !arm2);                             // R10
endmodule

bind pwm_timer16 pwm_timer16_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_on(pwm_on), .cnt(cnt),
    .m2_ev(m2_ev), .wr_en(wr_en), .addr(addr), .arm1(arm1), .arm2(arm2),
    .cap1(cap1), .oc1(oc1), .oc2(oc2), .irq(irq), .irq_mask(irq_mask),
    .cmp_out(cmp_out), .lvl2(lvl2), .oe(oe)
);

// File: tb/pwm_timer16_tb.sv
module pwm_timer16_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;
    logic       irq_mask = 1'b0;
    logic       cmp_out, irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .ext_clk(ext_clk), .irq_mask(irq_mask),
        .cmp_out(cmp_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Bring up PWM with the counter frozen (external source) during setup.
    task automatic setup_pwm(input int c1, input int c2, input logic l1,
                             input logic l2, input logic [1:0] ps,
                             input logic opm, input logic en);
        do_reset();
        wr(4'h1, 8'h18);
        wr(4'h4, 8'(c1 >> 8)); wr(4'h5, 8'(c1));
        wr(4'h6, 8'(c2 >> 8)); wr(4'h7, 8'(c2));
        wr(4'h0, {6'b0, l2, l1});
        wr(4'h1, {3'b0, ps, opm, 1'b1, en});
    endtask

    task automatic measure(output int hi, output int lo);
        int g = 0;
        hi = 0; lo = 0;
        while (cmp_out !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (cmp_out !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
        while (cmp_out === 1'b1 && g < 5000) begin hi++; @(negedge clk); g++; end
        while (cmp_out === 1'b0 && g < 5000) begin lo++; @(negedge clk); g++; end
    endtask

    function automatic int div_of(input int ps);
        return (ps == 0) ? 4 : (ps == 1) ? 2 : 8;
    endfunction

    initial begin
        logic [7:0] d;
        int hi, lo, dv;
        int c2s[3] = '{3, 10, 25};

        // R1: reset state
        do_reset();
        wr(4'h1, 8'h18);
        rd(4'h8, d); check("R1 cnt hi", d, 8'hFF);
        rd(4'h9, d); check("R1 cnt lo", d, 8'hFC);
        rd(4'h2, d); check("R1 flags", d, 0);
        check("R1 irq", irq, 0);
        check("R1 pin", cmp_out, 0);

        // R2/R3/R8: free run on external ticks, wrap, output-compare flags
        wr(4'h4, 8'h00); wr(4'h5, 8'h00);
        wr(4'h6, 8'h00); wr(4'h7, 8'h01);
        wr(4'h0, 8'h09);                 // lvl1=1, cmp_ie=1
        wr(4'h1, 8'h19);                 // ext ticks, oe=1, no PWM
        ext_pulses(5);
        rd(4'h8, d); check("R3 wrap hi", d, 8'h00);
        rd(4'h9, d); check("R2 ext count lo", d, 8'h01);
        check("R8 pin level1 outside pwm", cmp_out, 1);
        rd(4'h2, d); check("R8 oc1 only", d, 8'h02);
        ext_pulses(1);
        rd(4'h2, d); check("R8 oc1 and oc2", d, 8'h06);
        check("R7 irq from compare flags", irq, 1);
        irq_mask = 1'b1;
        @(negedge clk); check("R7 mask blocks irq", irq, 0);
        irq_mask = 1'b0;
        wr(4'h5, 8'h00);
        rd(4'h2, d); check("R8 low write clears oc1", d, 8'h04);

        // R10: high-byte write inhibits compare 2 (no reload, no flag)
        setup_pwm(1, 3, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
        wr(4'h6, 8'h00);
        ext_pulses(10);
        rd(4'h9, d); check("R10 no reload while inhibited", d, 8'h06);
        rd(4'h2, d); check("R10 no capture flag", d, 0);

        // R6/R7: capture flag in PWM and its clear sequence
        setup_pwm(1, 3, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
        wr(4'h0, 8'h06);                 // lvl2=1, cap_ie=1
        ext_pulses(8);
        rd(4'h9, d); check("R4 reload to FC", d, 8'hFC);
        check("R5 pin level2 after period", cmp_out, 1);
        check("R7 irq from capture", irq, 1);
        rd(4'h3, d);
        rd(4'h2, d); check("R6 flag survives lone low read", d, 8'h01);
        rd(4'h3, d);
        rd(4'h2, d); check("R6 flag cleared by sequence", d, 0);
        check("R7 irq drops", irq, 0);

        // R11: output disabled keeps pin low while PWM runs
        setup_pwm(2, 6, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (cmp_out) seen++;
            end
            check("R11 pin held low", seen, 0);
            rd(4'h2, d); check("R11 pwm still ran", d, 8'h01);
        end

        // R4/R5/R9: sweep prescalers and compare pairs, normal polarity
        for (int ps = 0; ps < 3; ps++) begin
            dv = div_of(ps);
            for (int k = 0; k < 3; k++) begin
                for (int j = 0; j < 3; j++) begin
                    int c2 = c2s[k];
                    int c1 = (j == 0) ? 0 : (j == 1) ? c2 / 2 : c2 - 1;
                    setup_pwm(c1, c2, 1'b0, 1'b1, 2'(ps), 1'(j == 1), 1'b1);
                    measure(hi, lo);
                    check("R5 high time", hi, (c1 + 5) * dv);
                    check("R4 low time / period", lo, (c2 - c1) * dv);
                end
            end
        end

        // R5: swapped levels, pulse is the compare difference
        for (int k = 0; k < 3; k++) begin
            int c2 = c2s[k];
            int c1 = c2 / 2;
            setup_pwm(c1, c2, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1);
            measure(hi, lo);
            check("R5 inverted high", hi, (c2 - c1) * 2);
            check("R9 inverted low", lo, (c1 + 5) * 2);
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule